// File: doc/BRIEF.md
# Frame Energy Conservation Checker

This block watches one streaming transform from outside. It sees two streams: the complex samples going into the transform and the complex samples coming out of it. Per sample it forms the squared magnitude, which is the real part squared plus the imaginary part squared. It adds each result into one of two wide running totals, one per side.

When the frame is over, the input total is scaled by a power of two to account for the gain of the transform length. The block then compares the scaled input total with the output total. A registered error flag is raised if the two differ by more than a tolerance.

A frame is delimited by two strobes. A start strobe clears both totals. An end strobe triggers the comparison. Only one squared magnitude per sample per side is needed, so a fault inside the transform can be detected without a second copy of the transform.

Top module: `parseval_checker`

## Requirements
- R1: While reset is high, and in the first cycle after it, `done` and `err` are 0.
- R2: In every cycle where `in_valid` is 1, the input total grows by in_re²+in_im². In every cycle where `out_valid` is 1, the output total grows by out_re²+out_im². Samples are signed two's complement. The two sides are independent and each takes at most one sample per cycle.
- R3: A cycle with `frame_start` high discards everything accumulated before it on both sides. A sample that is valid in that same cycle becomes the first term of the new frame.
- R4: Before comparison, the input total is multiplied by 2^SCALE_SH when SCALE_LEFT is 1. When SCALE_LEFT is 0 it is divided by 2^SCALE_SH, rounding down.
- R5: The error verdict is 1 exactly when |scaled input total − output total| > TOL. A difference equal to TOL gives 0.
- R6: `done` is 1 in the cycle after a cycle with `frame_end` high, and 0 otherwise. The verdict covers the samples presented in the `frame_end` cycle as well. `err` takes the verdict in the same cycle that `done` rises.
- R7: `err` keeps its value from one `frame_end` to the next, including across a new `frame_start`.
- R8: Cycles with a side's valid low leave that side's total unchanged, whatever its sample inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Clears both totals, first cycle of a frame |
| frame_end | input | 1 | Last cycle of a frame, triggers comparison |
| in_valid | input | 1 | Input-side sample present |
| in_re | input | IN_W | Input sample, real part, signed |
| in_im | input | IN_W | Input sample, imaginary part, signed |
| out_valid | input | 1 | Output-side sample present |
| out_re | input | OUT_W | Output sample, real part, signed |
| out_im | input | OUT_W | Output sample, imaginary part, signed |
| done | output | 1 | One-cycle pulse when a verdict is issued |
| err | output | 1 | Energy mismatch verdict of the last completed frame |

## Verification
Both results, `done` and `err`, are registered once at the rising edge that closes the `frame_end` cycle. Nothing else lies on their path, so they are due exactly one cycle after the end strobe. The bench drives every cycle on the falling edge and reads the pair on the falling edge one cycle after the end strobe was driven. It reads them again one cycle later to see `done` drop while `err` holds, and it reads `err` in the end-strobe cycle of the following frame to confirm it has not moved. The expected verdicts come from energies the bench sums itself, for a left-shift and a right-shift configuration fed the same stimulus.

// File: rtl/parseval_pkg.sv
package parseval_pkg;

    localparam int DEF_IN_W     = 12;
    localparam int DEF_OUT_W    = 14;
    localparam int DEF_ACC_W    = 39;
    localparam int DEF_SCALE_SH = 10;
    localparam int DEF_TOL      = 1;

    typedef struct packed {
        logic clear;
        logic valid;
    } acc_ctrl_t;

    typedef struct packed {
        logic done;
        logic err;
    } verdict_t;

endpackage

// File: rtl/energy_acc.sv
module energy_acc
    import parseval_pkg::*;
#(
    parameter int W     = 12,
    parameter int ACC_W = 39
) (
    input  logic                clk,
    input  logic                rst,
    input  acc_ctrl_t           ctrl,
    input  logic signed [W-1:0] re,
    input  logic signed [W-1:0] im,
    output logic [ACC_W-1:0]    sum_next,
    output logic [ACC_W-1:0]    acc_q
);

    localparam int SQ_W = 2 * W;

    logic signed [SQ_W-1:0] re_sq;
    logic signed [SQ_W-1:0] im_sq;
    logic [SQ_W-1:0]        mag_sq;
    logic [ACC_W-1:0]       term;
    logic [ACC_W:0]         wide_sum;

    assign re_sq    = re * re;
    assign im_sq    = im * im;
    assign mag_sq   = $unsigned(re_sq) + $unsigned(im_sq);
    assign term     = {{(ACC_W - SQ_W){1'b0}}, mag_sq};
    assign wide_sum = {1'b0, acc_q} + {1'b0, term};

    always_comb begin
        if (ctrl.clear)
            sum_next = ctrl.valid ? term : '0;
        else if (ctrl.valid)
            sum_next = wide_sum[ACC_W-1:0];
        else
            sum_next = acc_q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            acc_q <= '0;
        else
            acc_q <= sum_next;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (ctrl.valid && !ctrl.clear) |-> (wide_sum[ACC_W] == 1'b0)); // R2

    AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (ctrl.clear && !ctrl.valid) |=> (acc_q == '0)); // R3

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.clear && !ctrl.valid) |=> $stable(acc_q)); // R8

endmodule

// File: rtl/energy_cmp.sv
module energy_cmp
    import parseval_pkg::*;
#(
    parameter int ACC_W      = 39,
    parameter int SCALE_SH   = 10,
    parameter bit SCALE_LEFT = 1'b1,
    parameter int TOL        = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_end,
    input  logic [ACC_W-1:0] ein,
    input  logic [ACC_W-1:0] eout,
    output verdict_t         verdict
);

    localparam int SC_W = ACC_W + SCALE_SH + 1;
    localparam logic [SC_W:0] TOL_V = (SC_W + 1)'(TOL);

    logic [SC_W-1:0] ein_ext;
    logic [SC_W-1:0] eout_ext;
    logic [SC_W-1:0] ein_scaled;
    logic [SC_W:0]   diff;
    logic [SC_W:0]   abs_diff;
    logic            mismatch;

    assign ein_ext  = {{(SC_W - ACC_W){1'b0}}, ein};
    assign eout_ext = {{(SC_W - ACC_W){1'b0}}, eout};

    generate
        if (SCALE_LEFT) begin : g_left
            assign ein_scaled = ein_ext << SCALE_SH;
        end else begin : g_right
            assign ein_scaled = ein_ext >> SCALE_SH;
        end
    endgenerate

    assign diff     = {1'b0, ein_scaled} - {1'b0, eout_ext};
    assign abs_diff = diff[SC_W] ? (~diff + 1'b1) : diff;
    assign mismatch = abs_diff > TOL_V;

    always_ff @(posedge clk) begin
        if (rst) begin
            verdict <= '0;
        end else begin
            verdict.done <= frame_end;
            if (frame_end)
                verdict.err <= mismatch;
        end
    end

    AST_DONE_AFTER_END: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> verdict.done); // R6

    AST_DONE_ONLY_AFTER_END: assert property (@(posedge clk) disable iff (rst)
        !frame_end |=> !verdict.done); // R6

    AST_ERR_HELD: assert property (@(posedge clk) disable iff (rst)
        !frame_end |=> $stable(verdict.err)); // R7

endmodule

// File: rtl/parseval_checker.sv
module parseval_checker
    import parseval_pkg::*;
#(
    parameter int IN_W       = DEF_IN_W,
    parameter int OUT_W      = DEF_OUT_W,
    parameter int ACC_W      = DEF_ACC_W,
    parameter int SCALE_SH   = DEF_SCALE_SH,
    parameter bit SCALE_LEFT = 1'b1,
    parameter int TOL        = DEF_TOL
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    frame_start,
    input  logic                    frame_end,
    input  logic                    in_valid,
    input  logic signed [IN_W-1:0]  in_re,
    input  logic signed [IN_W-1:0]  in_im,
    input  logic                    out_valid,
    input  logic signed [OUT_W-1:0] out_re,
    input  logic signed [OUT_W-1:0] out_im,
    output logic                    done,
    output logic                    err
);

    acc_ctrl_t        in_ctrl;
    acc_ctrl_t        out_ctrl;
    logic [ACC_W-1:0] ein_next;
    logic [ACC_W-1:0] ein_q;
    logic [ACC_W-1:0] eout_next;
    logic [ACC_W-1:0] eout_q;
    verdict_t         verdict;

    assign in_ctrl  = '{clear: frame_start, valid: in_valid};
    assign out_ctrl = '{clear: frame_start, valid: out_valid};

    energy_acc #(.W(IN_W), .ACC_W(ACC_W)) u_in_acc (
        .clk      (clk),
        .rst      (rst),
        .ctrl     (in_ctrl),
        .re       (in_re),
        .im       (in_im),
        .sum_next (ein_next),
        .acc_q    (ein_q)
    );

    energy_acc #(.W(OUT_W), .ACC_W(ACC_W)) u_out_acc (
        .clk      (clk),
        .rst      (rst),
        .ctrl     (out_ctrl),
        .re       (out_re),
        .im       (out_im),
        .sum_next (eout_next),
        .acc_q    (eout_q)
    );

    energy_cmp #(
        .ACC_W      (ACC_W),
        .SCALE_SH   (SCALE_SH),
        .SCALE_LEFT (SCALE_LEFT),
        .TOL        (TOL)
    ) u_cmp (
        .clk       (clk),
        .rst       (rst),
        .frame_end (frame_end),
        .ein       (ein_next),
        .eout      (eout_next),
        .verdict   (verdict)
    );

    assign done = verdict.done;
    assign err  = verdict.err;

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (!done && !err)); // R1

    AST_ACC_CLEARED: assert property (@(posedge clk) disable iff (rst)
        (frame_start && !in_valid && !out_valid) |=> (ein_q == '0 && eout_q == '0)); // R3

endmodule

// File: tb/parseval_checker_test.sv
module parseval_checker_test;

    localparam int IN_W  = 6;
    localparam int OUT_W = 8;
    localparam int ACC_W = 24;
    localparam int SH    = 2;
    localparam int TOL   = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic frame_start = 1'b0;
    logic frame_end = 1'b0;
    logic in_valid = 1'b0;
    logic out_valid = 1'b0;
    logic signed [IN_W-1:0]  in_re = '0;
    logic signed [IN_W-1:0]  in_im = '0;
    logic signed [OUT_W-1:0] out_re = '0;
    logic signed [OUT_W-1:0] out_im = '0;
    logic done_l, err_l, done_r, err_r;

    always #4 clk = ~clk;

    parseval_checker #(.IN_W(IN_W), .OUT_W(OUT_W), .ACC_W(ACC_W),
        .SCALE_SH(SH), .SCALE_LEFT(1'b1), .TOL(TOL)) uut (
        .clk(clk), .rst(rst), .frame_start(frame_start), .frame_end(frame_end),
        .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
        .out_valid(out_valid), .out_re(out_re), .out_im(out_im),
        .done(done_l), .err(err_l));

    parseval_checker #(.IN_W(IN_W), .OUT_W(OUT_W), .ACC_W(ACC_W),
        .SCALE_SH(SH), .SCALE_LEFT(1'b0), .TOL(TOL)) uut_rs (
        .clk(clk), .rst(rst), .frame_start(frame_start), .frame_end(frame_end),
        .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
        .out_valid(out_valid), .out_re(out_re), .out_im(out_im),
        .done(done_r), .err(err_r));

    int checks = 0;
    int errors = 0;
    bit [31:0] lfsr = 32'h1234_5678;

    int n_in, n_out;
    logic signed [IN_W-1:0]  ire [64];
    logic signed [IN_W-1:0]  iim [64];
    logic signed [OUT_W-1:0] ore [64];
    logic signed [OUT_W-1:0] oim [64];
    bit gap [128];
    bit prev_l = 1'b0;
    bit prev_r = 1'b0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int rnd();
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        return int'(lfsr[15:0] ^ lfsr[31:16]);
    endfunction

    function automatic longint absl(input longint v);
        return (v < 0) ? -v : v;
    endfunction

    task automatic run_frame(input string tag);
        longint ein, eout, exp_l, exp_r;
        int pi, po, c;
        ein = 0;
        eout = 0;
        for (int i = 0; i < n_in; i++)
            ein += longint'(ire[i]) * ire[i] + longint'(iim[i]) * iim[i];
        for (int i = 0; i < n_out; i++)
            eout += longint'(ore[i]) * ore[i] + longint'(oim[i]) * oim[i];
        exp_l = (absl((ein << SH) - eout) > TOL) ? 1 : 0;
        exp_r = (absl((ein >> SH) - eout) > TOL) ? 1 : 0;
        pi = 0;
        po = 0;
        c = 0;
        do begin
            @(negedge clk);
            frame_start = (c == 0);
            in_valid = 1'b0;
            out_valid = 1'b0;
            // R8: idle cycles carry junk on the data pins
            in_re = IN_W'(rnd());
            in_im = IN_W'(rnd());
            out_re = OUT_W'(rnd());
            out_im = OUT_W'(rnd());
            if (!gap[c % 128]) begin
                if (pi < n_in) begin
                    in_valid = 1'b1;
                    in_re = ire[pi];
                    in_im = iim[pi];
                    pi++;
                end
                if (po < n_out) begin
                    out_valid = 1'b1;
                    out_re = ore[po];
                    out_im = oim[po];
                    po++;
                end
            end
            frame_end = (pi == n_in) && (po == n_out);
            c++;
        end while (!frame_end);
        // R7: verdict of previous frame still visible in this frame's last cycle
        check(err_l == prev_l, {"R7 held ", tag}, err_l, prev_l);
        check(err_r == prev_r, {"R7 held rs ", tag}, err_r, prev_r);
        @(negedge clk);
        frame_start = 1'b0;
        frame_end = 1'b0;
        in_valid = 1'b0;
        out_valid = 1'b0;
        check(done_l == 1'b1, {"R6 done ", tag}, done_l, 1);
        check(done_r == 1'b1, {"R6 done rs ", tag}, done_r, 1);
        check(err_l == exp_l[0], {"R5 R4 left ", tag}, err_l, exp_l);
        check(err_r == exp_r[0], {"R5 R4 right ", tag}, err_r, exp_r);
        @(negedge clk);
        check(done_l == 1'b0, {"R6 pulse ", tag}, done_l, 0);
        check(err_l == exp_l[0], {"R7 after ", tag}, err_l, exp_l);
        prev_l = exp_l[0];
        prev_r = exp_r[0];
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 128; i++) gap[i] = 1'b0;
        repeat (3) @(negedge clk);
        check(done_l == 1'b0 && err_l == 1'b0, "R1 in reset", {done_l, err_l}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(done_l == 1'b0 && err_l == 1'b0, "R1 after reset", {done_l, err_l}, 0);
        check(done_r == 1'b0 && err_r == 1'b0, "R1 after reset rs", {done_r, err_r}, 0);

        // R5 tolerance edge: output exceeds 4x input energy by d
        for (int a = -32; a < 32; a += 3) begin
            for (int d = 0; d < 6; d++) begin
                n_in = 1;
                ire[0] = IN_W'(a);
                iim[0] = IN_W'(a / 2);
                n_out = 1 + d;
                ore[0] = OUT_W'(2 * a);
                oim[0] = OUT_W'(2 * (a / 2));
                for (int k = 1; k <= d; k++) begin
                    ore[k] = 1;
                    oim[k] = 0;
                end
                run_frame($sformatf("edge a=%0d d=%0d", a, d));
            end
        end

        // R5 negative side: input energy one larger, scaled difference is 4
        n_in = 2;
        ire[0] = 5; iim[0] = 0; ire[1] = 1; iim[1] = 0;
        n_out = 1;
        ore[0] = 10; oim[0] = 0;
        run_frame("neg diff");

        // R2 R3 R8: random frames with idle gaps, clear at start
        for (int f = 0; f < 120; f++) begin
            n_in = 1 + (rnd() % 40);
            n_out = 1 + (rnd() % 40);
            for (int i = 0; i < n_in; i++) begin
                ire[i] = IN_W'(rnd());
                iim[i] = IN_W'(rnd());
            end
            if (f % 2 == 0) begin
                // frame built to be near-consistent so both verdicts occur
                n_out = n_in;
                for (int i = 0; i < n_in; i++) begin
                    ore[i] = OUT_W'(2 * int'(ire[i]));
                    oim[i] = OUT_W'(2 * int'(iim[i]));
                end
                if (f % 4 == 0) oim[0] = oim[0] + 8'sd1;
            end else begin
                for (int i = 0; i < n_out; i++) begin
                    ore[i] = OUT_W'(rnd() % 20);
                    oim[i] = OUT_W'(rnd() % 20);
                end
            end
            for (int i = 0; i < 128; i++) gap[i] = ((rnd() & 3) == 0);
            run_frame($sformatf("R2 rand %0d", f));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule